// File: doc/BRIEF.md
# Gated Clock Fanout with Source Select

This block takes two clock sources, a fast main clock and a slower scan/test clock, picks one with a select pin, and drives it to five output pairs. Each pair carries the gated clock on its true leg and the inverse on its complement leg. All five pairs are copies of one gated signal.

An active-low enable controls the gating. The enable is not applied directly. A register that runs on the falling edge of the selected clock captures it, and that register drives an AND gate. Because of this, the outputs can turn on or off only while the selected clock is low. A high pulse at the outputs is therefore always as wide as the source's high phase. The block has no reset pin. At power-up the enable register holds the disabled state until the first falling edge samples the enable pin.

The block carries only clocks and plain control pins. There is no data stream, so it has no valid/ready interface.

Top module: `clkfan_gated`

## Requirements
- R1: With `sel_scan` at 0, the main clock `clk_sys` reaches the outputs. With `sel_scan` at 1, the scan clock `clk_scan` reaches the outputs.
- R2: A `sel_scan` pin left at high impedance (or unknown) selects the main clock, the same as a 0.
- R3: While the retimed enable is inactive (`en_n` sampled as 1), every true output stays 0 and every complement output stays 1.
- R4: The block samples `en_n` only on the falling edge of the selected clock. A change on `en_n` that returns to its old value between two falling edges has no effect.
- R5: The outputs start or stop only during the low phase of the selected clock. A change on `en_n` during a high phase affects neither the current pulse nor the current idle phase. While the clock is low, no true output is ever high.
- R6: All true outputs are identical, and each complement output is the exact inverse of its true output.
- R7: Every high pulse on a true output lasts exactly one high phase of the selected source clock.
- R8: From power-up until the first falling edge of the selected clock, the outputs are held off (true low, complement high), even if `en_n` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_sys | input | 1 | Main system clock |
| clk_scan | input | 1 | Slower scan/test clock |
| sel_scan | input | 1 | Source select: 1 selects scan clock; 0 or floating selects main clock |
| en_n | input | 1 | Active-low common enable, retimed on the falling edge |
| q | output | NUM_PAIRS (5) | Gated clock, true legs |
| q_n | output | NUM_PAIRS (5) | Gated clock, complement legs |

## Verification
The hardest case to reach from the ports is an enable change that lands inside a high phase of the selected clock. A direct gate would cut the pulse at that point, but this design must leave the pulse whole. The stimulus reaches this case in two ways. First, it moves `en_n` at random offsets across the whole clock period for both sources, whose periods differ. Second, it places directed edges one nanosecond after a rising edge and inside a single low phase. A monitor measures the width of every true-output pulse against the selected source's high phase.

// File: rtl/clkfan_pkg.sv
package clkfan_pkg;
  localparam int unsigned DEF_PAIRS = 5;

  typedef enum logic {
    SRC_MAIN = 1'b0,
    SRC_SCAN = 1'b1
  } src_e;
endpackage

// File: rtl/clkfan_src_mux.sv
module clkfan_src_mux
  import clkfan_pkg::*;
(
  input  logic clk_main_i,
  input  logic clk_scan_i,
  input  logic sel_i,
  output logic clk_o
);
  src_e src;

  // Only a solid 1 selects the scan clock; z or x falls back to main (R2)
  always_comb begin
    src = (sel_i === 1'b1) ? SRC_SCAN : SRC_MAIN;
  end

  always_comb begin
    case (src)
      SRC_SCAN: clk_o = clk_scan_i;
      default:  clk_o = clk_main_i;
    endcase
  end
endmodule

// File: rtl/clkfan_en_retime.sv
module clkfan_en_retime (
  input  logic clk_i,
  input  logic en_n_i,
  output logic gate_o
);
  // Power-up value is "off"; there is no reset pin (R8)
  logic gate_q = 1'b0;
  logic armed  = 1'b0;

  always_ff @(negedge clk_i) begin
    gate_q <= ~en_n_i;
    armed  <= 1'b1;
  end

  assign gate_o = gate_q;

  // R4: the gate holds what en_n was at the previous falling edge
  p_retime_r4: assert property (@(negedge clk_i) disable iff (!armed)
    gate_q == !$past(en_n_i));

  // R3: a high en_n at one falling edge leaves the gate closed afterwards
  p_idle_r3: assert property (@(negedge clk_i) disable iff (!armed)
    $past(en_n_i) |-> !gate_q);
endmodule

// File: rtl/clkfan_fanout.sv
module clkfan_fanout #(
  parameter int unsigned NUM_PAIRS = 5
) (
  input  logic                 clk_i,
  input  logic                 gate_i,
  output logic [NUM_PAIRS-1:0] q_o,
  output logic [NUM_PAIRS-1:0] q_n_o
);
  logic gated;

  assign gated = clk_i & gate_i;

  for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_pair
    assign q_o[i]   = gated;
    assign q_n_o[i] = ~gated;
  end
endmodule

// File: rtl/clkfan_gated.sv
module clkfan_gated #(
  parameter int unsigned NUM_PAIRS = clkfan_pkg::DEF_PAIRS
) (
  input  logic                 clk_sys,
  input  logic                 clk_scan,
  input  logic                 sel_scan,
  input  logic                 en_n,
  output logic [NUM_PAIRS-1:0] q,
  output logic [NUM_PAIRS-1:0] q_n
);
  localparam logic [NUM_PAIRS-1:0] ALL_OFF = '0;

  logic clk_sel;
  logic gate;
  logic seen_edge = 1'b0;

  clkfan_src_mux u_mux (
    .clk_main_i (clk_sys),
    .clk_scan_i (clk_scan),
    .sel_i      (sel_scan),
    .clk_o      (clk_sel)
  );

  clkfan_en_retime u_retime (
    .clk_i  (clk_sel),
    .en_n_i (en_n),
    .gate_o (gate)
  );

  clkfan_fanout #(.NUM_PAIRS(NUM_PAIRS)) u_fan (
    .clk_i  (clk_sel),
    .gate_i (gate),
    .q_o    (q),
    .q_n_o  (q_n)
  );

  always_ff @(negedge clk_sel) seen_edge <= 1'b1;

  // R5: just before every rising edge (clock low) no true output is high
  p_low_before_rise_r5: assert property (@(posedge clk_sel) disable iff (!seen_edge)
    q == ALL_OFF);

  // R6: complement legs mirror the true legs at the output pins
  p_comp_r6: assert property (@(posedge clk_sel) disable iff (!seen_edge)
    q_n == ~q);
endmodule

// File: tb/clkfan_gated_test.sv
`timescale 1ns/1ps
module clkfan_gated_test;
  localparam int unsigned NP = 5;
  localparam realtime HP_SYS  = 2.5;
  localparam realtime HP_SCAN = 8.5;
  localparam logic [NP-1:0] ONES = '1;

  logic clk_sys = 1'b1;
  logic clk_scan = 1'b1;
  logic sel_scan;
  logic en_n;
  logic [NP-1:0] q, q_n;

  int checks = 0;
  int fails = 0;
  int rises = 0;
  int width_bad = 0;
  int pulses = 0;
  realtime t_rise = 0.0;
  realtime hp_exp = HP_SYS;

  clkfan_gated #(.NUM_PAIRS(NP)) uut (
    .clk_sys (clk_sys), .clk_scan (clk_scan), .sel_scan (sel_scan),
    .en_n (en_n), .q (q), .q_n (q_n)
  );

  always #(HP_SYS)  clk_sys  = ~clk_sys;
  always #(HP_SCAN) clk_scan = ~clk_scan;

  // R7 monitor: every high pulse on q[0] must match the source high phase
  always @(posedge q[0]) begin
    rises++;
    t_rise = $realtime;
  end
  always @(negedge q[0]) begin
    pulses++;
    if (($realtime - t_rise) < hp_exp - 0.01 || ($realtime - t_rise) > hp_exp + 0.01) begin
      width_bad++;
      $display("FAIL R7 pulse width %0t expected %0t", $realtime - t_rise, hp_exp);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_neg(input bit scan);
    if (scan) @(negedge clk_scan); else @(negedge clk_sys);
  endtask

  task automatic wait_pos(input bit scan);
    if (scan) @(posedge clk_scan); else @(posedge clk_sys);
  endtask

  typedef struct packed {
    logic       sel;
    logic       en_n;
    logic [7:0] win;
    logic [7:0] exp_rises;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{1'b0, 1'b0, 8'd8,  8'd8},   // R1 main, enabled
    '{1'b1, 1'b0, 8'd6,  8'd6},   // R1 scan, enabled
    '{1'b0, 1'b1, 8'd8,  8'd0},   // R3 main, disabled
    '{1'b1, 1'b1, 8'd5,  8'd0},   // R3 scan, disabled
    '{1'b1, 1'b0, 8'd3,  8'd3},
    '{1'b0, 1'b0, 8'd12, 8'd12},
    '{1'b1, 1'b1, 8'd4,  8'd0},
    '{1'b0, 1'b0, 8'd2,  8'd2}
  };

  initial begin
    #(200000 * 5);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    sel_scan = 1'b0;
    en_n = 1'b0;
    // R8: clock high at start, en_n low, but the gate has not been loaded yet
    #1;
    check(q == '0 && q_n == ONES, "R8 power-up outputs off", int'(q), 0);

    // Vector table walk
    foreach (VEC[i]) begin
      en_n = 1'b1;
      #60;
      sel_scan = VEC[i].sel;
      hp_exp = VEC[i].sel ? HP_SCAN : HP_SYS;
      #60;
      #($urandom_range(0, VEC[i].sel ? 1700 : 500) * 0.01);
      en_n = VEC[i].en_n;
      wait_neg(VEC[i].sel);
      #0.01;
      rises = 0;
      repeat (int'(VEC[i].win)) wait_neg(VEC[i].sel);
      #0.01;
      check(rises == int'(VEC[i].exp_rises),
            VEC[i].en_n ? "R3 disabled rise count" : "R1 enabled rise count",
            rises, int'(VEC[i].exp_rises));
      wait_pos(VEC[i].sel);
      #0.5;
      if (VEC[i].en_n)
        check(q == '0 && q_n == ONES, "R3 held outputs", int'(q), 0);
      else
        check(q == ONES && q_n == '0, "R6 pairs match", int'(q), int'(ONES));
    end

    // R5: enable asserted in high phase does not start the current pulse
    en_n = 1'b1;
    #60;
    sel_scan = 1'b0;
    hp_exp = HP_SYS;
    #60;
    @(posedge clk_sys);
    #1 en_n = 1'b0;
    #0.5;
    check(q == '0, "R5 no late start", int'(q), 0);
    @(posedge clk_sys);
    #0.5;
    check(q == ONES, "R5 starts after falling edge", int'(q), int'(ONES));

    // R5: disable in high phase leaves the current pulse whole
    #0.5 en_n = 1'b1;
    #0.5;
    check(q == ONES, "R5 pulse not truncated", int'(q), int'(ONES));
    @(posedge clk_sys);
    #0.5;
    check(q == '0, "R5 stops after falling edge", int'(q), 0);

    // R4: en_n glitch within one low phase is ignored
    en_n = 1'b0;
    @(negedge clk_sys);
    @(negedge clk_sys);
    #0.5 en_n = 1'b1;
    #1.0 en_n = 1'b0;
    @(posedge clk_sys);
    #0.5;
    check(q == ONES, "R4 low-phase glitch ignored", int'(q), int'(ONES));

    // R2: floating select behaves as main clock
    en_n = 1'b1;
    #60;
    sel_scan = 1'bz;
    hp_exp = HP_SYS;
    #60;
    en_n = 1'b0;
    @(negedge clk_sys);
    #0.01;
    rises = 0;
    repeat (10) @(negedge clk_sys);
    #0.01;
    check(rises == 10, "R2 floating select picks main", rises, 10);

    #20;
    check(width_bad == 0 && pulses > 50, "R7 full-width pulses", width_bad, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule